// File: doc/BRIEF.md
# Bypass-Capable Synchronous FIFO Queue

This block is a single-clock queue with a valid/ready push side and a valid/ready pop side. It also reports how many words it holds, and flags for empty and full. The `FWFT` parameter picks one of two read styles behind the same ports. In the fall-through style, the oldest word sits on `out_data` whenever `out_valid` is high. In the registered style, a pop moves the oldest word into an output staging register, and the word shows on `out_data` one cycle after the pop.

The oldest word is held in a head register. The words behind it sit in a synchronous-read store of `DEPTH-1` slots, which is padded to at least two addresses. A push into an empty queue, or into a queue whose only word is being popped, goes straight into the head register and never passes through the store. Because of this, a depth of one needs no store traffic at all: both pointers stay at address zero, and the spare store entries are never touched. The store registers its read address one cycle ahead. A write to the address being prefetched is forwarded around the store, so nothing relies on the memory writing through to its read port.

A three-state head controller sequences the design. **HD_EMPTY** means no word is held. **HD_LIVE** means only the head register holds a word. **HD_SPILL** means the head register holds a word and the store holds at least one more. Its transitions are these:

- fill: HD_EMPTY to HD_LIVE on an accepted push.
- drain: HD_LIVE to HD_EMPTY on a pop with no push.
- refill: HD_LIVE stays in HD_LIVE on a push and a pop together, with the new word bypassing into the head.
- spill: HD_LIVE to HD_SPILL on a push with no pop.
- unspill: HD_SPILL to HD_LIVE on a pop with no push while the store holds exactly one word.
- advance: HD_SPILL stays in HD_SPILL on any other pop, with the head reloading from the store.

Top module: `bypass_queue`

## Requirements
- R1: While `rst_n` is low, and after it is released: `level` is 0, `empty` is 1, `full` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: With `FWFT`=1, whenever `out_valid` is 1, `out_data` equals the oldest stored word. Words leave in the order they were accepted.
- R3: With `FWFT`=0, a pop accepted at clock edge t places the popped word on `out_data` from the cycle after edge t. It stays there until the next accepted pop.
- R4: A push accepted into an empty queue raises `out_valid` in the cycle after the edge. With `FWFT`=1, `out_data` then already shows that word.
- R5: `level` counts stored words from 0 to `DEPTH`. `full` is 1 exactly when `level` equals `DEPTH`, and `empty` is 1 exactly when `level` is 0. `in_ready` is the inverse of `full`, and `out_valid` is the inverse of `empty`.
- R6: A push offered while `full` is 1 is dropped. With no pop in the same cycle, `level` and the queue contents stay unchanged.
- R7: A pop offered while `empty` is 1 is ignored. `level` rises only if a push is accepted in that cycle.
- R8: A push and a pop accepted in the same cycle leave `level` unchanged. The pushed word joins the tail, and the head advances.
- R9: `DEPTH`=1 works in both read styles. The queue holds one word, and the store address stays at zero.
- R10: For a `DEPTH` that is not a power of two (3), the pointers wrap modulo the slot count, and the order is preserved across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Queue can accept a push |
| in_data | input | WIDTH | Word to push |
| out_valid | output | 1 | A word is available to pop |
| out_ready | input | 1 | Pop request |
| out_data | output | WIDTH | Head word (FWFT=1) or last popped word (FWFT=0) |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds DEPTH words |

## Verification
The assertions assume that `in_valid` and `out_ready` are known and settled at each rising edge. They also assume that a dropped push or an ignored pop may be offered freely, so they make no demand that the source holds back while the queue is full or empty. The stimulus drives every input on the falling edge and draws it from a seeded generator. That generator cycles through fill-heavy, drain-heavy and balanced phases, so that the full, empty, refill and unspill transitions each occur many times. Those phases run at depths 1, 2, 3 and 8 in both read styles.

// File: rtl/bq_pkg.sv
package bq_pkg;

    // Occupancy of the head register versus the backing store.
    typedef enum logic [1:0] {
        HD_EMPTY = 2'd0,   // nothing held
        HD_LIVE  = 2'd1,   // only the head register holds a word
        HD_SPILL = 2'd2    // head holds a word, store holds one or more
    } head_state_e;

    // Physical store size: padded so an address of at least one bit exists.
    function automatic int store_phys(input int slots);
        return (slots < 2) ? 2 : slots;
    endfunction

endpackage

// File: rtl/bq_ptr.sv
// Wrapping slot pointer. Counts modulo SLOTS; for SLOTS of 0 or 1 the wrap
// point is slot 0, so the pointer is held at zero forever.
module bq_ptr #(
    parameter int SLOTS = 3,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt
);

    localparam int LAST = (SLOTS > 1) ? SLOTS - 1 : 0;

    always_comb begin
        ptr_nxt = ptr;
        if (adv) begin
            if (ptr == AW'(LAST)) ptr_nxt = '0;
            else                  ptr_nxt = ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

endmodule

// File: rtl/bq_store.sv
// Synchronous-read store. The read address is registered one cycle early;
// a write landing on that same address is captured and forwarded, so the
// array never needs write-through behaviour.
module bq_store #(
    parameter int WIDTH = 16,
    parameter int SLOTS = 3,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    localparam int PHYS = bq_pkg::store_phys(SLOTS);

    logic [WIDTH-1:0] cells [PHYS];
    logic [WIDTH-1:0] rd_q;
    logic [WIDTH-1:0] fwd_q;
    logic             fwd_sel_q;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= '0;
            fwd_q     <= '0;
            fwd_sel_q <= 1'b0;
        end else begin
            rd_q      <= cells[raddr];
            fwd_sel_q <= we && (waddr == raddr);
            fwd_q     <= wdata;
        end
    end

    assign rdata = fwd_sel_q ? fwd_q : rd_q;

endmodule

// File: rtl/bq_ctrl.sv
// Head controller: decides where each accepted push lands (head or store),
// when the head reloads from the store, and keeps the word count.
module bq_ctrl
    import bq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          head_valid,
    output logic [CW-1:0] level,
    output logic          head_load,
    output logic          head_from_mem,
    output logic          mem_we,
    output logic          rd_adv
);

    head_state_e state_q, state_d;
    logic        push_ok;
    logic        pop_ok;
    logic        full_w;

    assign full_w     = (level == CW'(DEPTH));
    assign in_ready   = !full_w;
    assign head_valid = (state_q != HD_EMPTY);
    assign push_ok    = in_valid && !full_w;
    assign pop_ok     = out_ready && head_valid;

    // State register and word count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HD_EMPTY;
            level   <= '0;
        end else begin
            state_q <= state_d;
            level   <= level + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Transitions and datapath controls.
    always_comb begin
        state_d       = state_q;
        head_load     = 1'b0;
        head_from_mem = 1'b0;
        mem_we        = 1'b0;
        rd_adv        = 1'b0;
        unique case (state_q)
            HD_EMPTY: begin
                // fill
                head_load = push_ok;
                if (push_ok) state_d = HD_LIVE;
            end
            HD_LIVE: begin
                if (pop_ok) begin
                    // refill (bypass) or drain
                    head_load = push_ok;
                    state_d   = push_ok ? HD_LIVE : HD_EMPTY;
                end else if (push_ok) begin
                    // spill
                    mem_we  = 1'b1;
                    state_d = HD_SPILL;
                end
            end
            HD_SPILL: begin
                mem_we = push_ok;
                if (pop_ok) begin
                    head_load     = 1'b1;
                    head_from_mem = 1'b1;
                    rd_adv        = 1'b1;
                    // unspill when the last stored word moves into the head
                    if (!push_ok && level == CW'(2)) state_d = HD_LIVE;
                    else                             state_d = HD_SPILL;
                end
            end
            default: state_d = HD_EMPTY;
        endcase
    end

endmodule

// File: rtl/bypass_queue.sv
// Single-clock queue, selectable fall-through or registered read style.
module bypass_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    parameter bit FWFT  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [WIDTH-1:0]           in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [WIDTH-1:0]           out_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);

    localparam int SLOTS = DEPTH - 1;                  // words behind the head
    localparam int PHYS  = bq_pkg::store_phys(SLOTS);
    localparam int AW    = $clog2(PHYS);
    localparam int CW    = $clog2(DEPTH + 1);

    logic             head_valid;
    logic             head_load;
    logic             head_from_mem;
    logic             mem_we;
    logic             rd_adv;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    wr_ptr_nxt;
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    rd_ptr_nxt;
    logic [WIDTH-1:0] mem_rdata;
    logic [WIDTH-1:0] head_q;

    bq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .in_ready     (in_ready),
        .head_valid   (head_valid),
        .level        (level),
        .head_load    (head_load),
        .head_from_mem(head_from_mem),
        .mem_we       (mem_we),
        .rd_adv       (rd_adv)
    );

    bq_ptr #(.SLOTS(SLOTS), .AW(AW)) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (mem_we),
        .ptr    (wr_ptr),
        .ptr_nxt(wr_ptr_nxt)
    );

    bq_ptr #(.SLOTS(SLOTS), .AW(AW)) u_rptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (rd_adv),
        .ptr    (rd_ptr),
        .ptr_nxt(rd_ptr_nxt)
    );

    // Prefetch at the pointer's next value so the head can reload in one cycle.
    bq_store #(.WIDTH(WIDTH), .SLOTS(SLOTS), .AW(AW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(wr_ptr),
        .wdata(in_data),
        .raddr(rd_ptr_nxt),
        .rdata(mem_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         head_q <= '0;
        else if (head_load) head_q <= head_from_mem ? mem_rdata : in_data;
    end

    assign out_valid = head_valid;
    assign empty     = (level == '0);
    assign full      = (level == CW'(DEPTH));

    generate
        if (FWFT) begin : g_fall_through
            assign out_data = head_q;
        end else begin : g_staged
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       stage_q <= '0;
                else if (out_valid && out_ready)  stage_q <= head_q;
            end
            assign out_data = stage_q;
        end
    endgenerate

endmodule

// File: rtl/bq_chk.sv
// Port-level properties of bypass_queue, attached by bind below.
module bq_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       empty,
    input logic                       full
);

    localparam int CW = $clog2(DEPTH + 1);

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R5
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == !full);

    // R5
    valid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == !empty);

    // R5
    push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(out_valid && out_ready))
        |=> level == $past(level) + CW'(1));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(out_valid && out_ready)) |=> $stable(level));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !in_valid) |=> empty);

    // R8
    pair_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_valid && out_ready) |=> $stable(level));

    // R4
    bypass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && in_valid) |=> out_valid);

endmodule

bind bypass_queue bq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .level    (level),
    .empty    (empty),
    .full     (full)
);

// File: tb/sim_bypass_queue.sv
// One traffic lane: a queue instance plus a behavioural reference queue.
module sim_lane #(
    parameter int DEPTH = 4,
    parameter bit FWFT  = 1'b1,
    parameter int SEED  = 1,
    parameter int STEPS = 2400
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_cmp,
    output int   n_bad,
    output logic done
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          in_valid, out_ready;
    logic [15:0]   in_data;
    logic          in_ready, out_valid, empty, full;
    logic [15:0]   out_data;
    logic [CW-1:0] level;

    bypass_queue #(.WIDTH(16), .DEPTH(DEPTH), .FWFT(FWFT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .level(level), .empty(empty), .full(full)
    );

    logic [15:0] model [$];
    logic [15:0] last_pop;
    bit          have_pop;
    bit          was_bypass, was_blocked, was_underflow, was_pair;
    int unsigned rng;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (depth %0d, fwft %0d) t=%0t: actual %0d expected %0d",
                     req, DEPTH, FWFT, $time, act, exp);
        end
    endtask

    function automatic int unsigned next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic compare();
        int    sz;
        string ltag;
        string dtag;
        sz = model.size();
        ltag = was_pair ? "R8" : was_blocked ? "R6" : was_underflow ? "R7" : "R5";
        chk(ltag, int'(level), sz);
        chk("R5", int'(empty), int'(sz == 0));
        chk("R5", int'(full), int'(sz == DEPTH));
        chk("R5", int'(in_ready), int'(sz < DEPTH));
        chk("R5", int'(out_valid), int'(sz > 0));
        if (FWFT && sz > 0) begin
            dtag = was_bypass ? "R4" : (DEPTH == 1) ? "R9" : (DEPTH == 3) ? "R10" : "R2";
            chk(dtag, int'(out_data), int'(model[0]));
        end
        if (!FWFT && have_pop) begin
            dtag = (DEPTH == 1) ? "R9" : (DEPTH == 3) ? "R10" : "R3";
            chk(dtag, int'(out_data), int'(last_pop));
        end
    endtask

    initial begin
        bit push_acc, pop_acc;
        int sz, phase, pv, pr;
        n_cmp = 0; n_bad = 0; done = 1'b0;
        in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
        have_pop = 0; was_bypass = 0; was_blocked = 0; was_underflow = 0; was_pair = 0;
        rng = 32'h1234_5678 ^ (SEED * 32'h9E37_79B9);
        @(negedge clk);
        // R1: values held during reset
        chk("R1", int'(level), 0);
        chk("R1", int'(empty), 1);
        chk("R1", int'(full), 0);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(in_ready), 1);
        wait (rst_n);
        for (int c = 0; c < STEPS; c++) begin
            compare();
            phase = (c / 150) % 3;
            pv = (phase == 0) ? 80 : (phase == 1) ? 25 : 55;
            pr = (phase == 0) ? 25 : (phase == 1) ? 85 : 55;
            in_valid  = (next_rand() % 100) < pv;
            in_data   = 16'(next_rand());
            out_ready = (next_rand() % 100) < pr;
            sz = model.size();
            push_acc = in_valid && (sz < DEPTH);
            pop_acc  = out_ready && (sz > 0);
            was_bypass    = push_acc && (sz == 0);
            was_blocked   = in_valid && (sz == DEPTH) && !pop_acc;
            was_underflow = out_ready && (sz == 0);
            was_pair      = push_acc && pop_acc;
            @(posedge clk);
            if (pop_acc) begin
                last_pop = model.pop_front();
                have_pop = 1;
            end
            if (push_acc) model.push_back(in_data);
            @(negedge clk);
        end
        compare();
        in_valid = 1'b0; out_ready = 1'b0;
        done = 1'b1;
    end

endmodule

module sim_bypass_queue;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    int                cmp [LANES];
    int                bad [LANES];
    logic [LANES-1:0]  done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Lanes 0-3: fall-through, depths 1,2,3,8; lanes 4-7: registered read.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int LD = (i % 4 == 0) ? 1 : (i % 4 == 1) ? 2 : (i % 4 == 2) ? 3 : 8;
            sim_lane #(.DEPTH(LD), .FWFT(i < 4), .SEED(i + 7)) lane (
                .clk(clk), .rst_n(rst_n),
                .n_cmp(cmp[i]), .n_bad(bad[i]), .done(done[i])
            );
        end
    endgenerate

    initial begin
        int total_cmp, total_bad, cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (done != {LANES{1'b1}} && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        #1;
        total_cmp = 0;
        total_bad = 0;
        for (int i = 0; i < LANES; i++) begin
            total_cmp += cmp[i];
            total_bad += bad[i];
        end
        if (done != {LANES{1'b1}}) begin
            total_cmp++;
            total_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_cmp, total_bad);
        $finish;
    end

endmodule